// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit watches 32 general-purpose input pins and turns their activity into interrupt status. Each pin is brought into the clock domain through a two-flop synchroniser. It is then judged either by level (active high or active low) or by edge. For edge detection, rising and falling edges are selected separately. An edge-mode pin can latch its event until software clears it, or report it for one clock only.

Software reaches the unit through a 16-bit register bus. Every per-pin function is split into two 16-bit halves: pins 0–15 in the lower half and pins 16–31 in the upper half. Status bits are cleared by writing ones. The unit drives three outputs:
- a registered combined interrupt line;
- the number of the pending pin that should be served first, with the lower half always searched first;
- a flag saying whether any enabled pin is pending at all.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration register reads 0 (all pins disabled, level mode, active low, hold off, both edge selects off), `pendValid`, `pendPin` and `irqOut` are 0.
- R2: Register map, byte offsets with the upper half (pins 16–31, bit i = pin 16+i) at offset +2. Status 0x08, enable 0x0C, detect type 0x10, polarity 0x14, hold 0x18, falling select 0x20, rising select 0x24. Each configuration register reads back the last value written to it, and no other register changes.
- R3: Writing 1 to a status bit of an edge-mode pin with hold set clears it; writing 0 leaves it unchanged.
- R4: When the detect type bit is 0 (level mode), the status bit equals the qualified input on every clock. The input is active high when the polarity bit is 1 and active low when it is 0. The hold bit is ignored, and a write of 1 has no lasting effect while the level is active.
- R5: When the detect type bit is 1 (edge mode), the falling select bit enables detection of 1→0 input edges and the rising select bit enables detection of 0→1 edges. With both select bits set, both edges are detected; with neither set, no event is detected.
- R6: In edge mode with hold set, a detected event stays in status until cleared. With hold clear, the status bit is 1 for exactly one clock per event.
- R7: A pin is pending when its status and enable bits are both 1. `pendValid` is 1 when any pin is pending. `pendPin` is the lowest pending pin of pins 0–15 if there is one, and otherwise the lowest pending pin of pins 16–31.
- R8: With no pin pending, `pendValid` and `pendPin` are 0, even if status bits of disabled pins are set.
- R9: `irqOut` equals the OR of all pending bits one clock earlier.
- R10: An input change is reflected in status on the third rising clock edge after it is applied, and not on the second.
- R11: If an edge event is detected in the same clock as a write of 1 to its status bit in hold mode, the status bit remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Raw general-purpose input pins |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Registered combined interrupt |
| pendValid | output | 1 | Some enabled pin is pending |
| pendPin | output | 5 | Number of the pin to serve first |

## Verification
A wrong detect-mode or edge decision in one pin appears at that pin's status bit three clocks after the input moves, and at `pendValid`/`pendPin` in the same cycle. The sweep covers every pin against every mode combination and checks both points. A stale latched event or a clear that is lost shows up at the next status read. A wrong half priority shows up as a wrong `pendPin` as soon as two pins in different halves are pending. The combined line is checked one clock after the pending set settles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TRIG   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HOLD   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_FALL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE   = 8'h24;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_STATUS, KIND_ENABLE, KIND_TRIG,
    KIND_LEVEL, KIND_HOLD, KIND_FALL, KIND_RISE
  } regKindT;

  // Strobes from the decoder to the datapath; index = register half
  typedef struct packed {
    logic [1:0] wrStatus;
    logic [1:0] wrEnable;
    logic [1:0] wrTrig;
    logic [1:0] wrLevel;
    logic [1:0] wrHold;
    logic [1:0] wrFall;
    logic [1:0] wrRise;
    regKindT    rdKind;
    logic       rdHalf;
  } ctrlStrobeT;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobeT        strobe
);
  logic [ADDR_W-1:0] baseAddr;
  logic              half;
  regKindT           kind;

  assign baseAddr = {busAddr[ADDR_W-1:2], 2'b00};
  assign half     = busAddr[1];

  always_comb begin
    kind = KIND_NONE;
    if (!busAddr[0]) begin
      case (baseAddr)
        OFF_STATUS: kind = KIND_STATUS;
        OFF_ENABLE: kind = KIND_ENABLE;
        OFF_TRIG:   kind = KIND_TRIG;
        OFF_LEVEL:  kind = KIND_LEVEL;
        OFF_HOLD:   kind = KIND_HOLD;
        OFF_FALL:   kind = KIND_FALL;
        OFF_RISE:   kind = KIND_RISE;
        default:    kind = KIND_NONE;
      endcase
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.rdKind = kind;
    strobe.rdHalf = half;
    if (busWrEn) begin
      case (kind)
        KIND_STATUS: strobe.wrStatus[half] = 1'b1;
        KIND_ENABLE: strobe.wrEnable[half] = 1'b1;
        KIND_TRIG:   strobe.wrTrig[half]   = 1'b1;
        KIND_LEVEL:  strobe.wrLevel[half]  = 1'b1;
        KIND_HOLD:   strobe.wrHold[half]   = 1'b1;
        KIND_FALL:   strobe.wrFall[half]   = 1'b1;
        KIND_RISE:   strobe.wrRise[half]   = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: at most one register half is written per bus cycle
  assert_one_write_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStatus, strobe.wrEnable, strobe.wrTrig, strobe.wrLevel,
              strobe.wrHold, strobe.wrFall, strobe.wrRise}));

  // R2: a write to a decoded offset produces a strobe
  assert_write_decoded_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && kind != KIND_NONE) |->
      ($countones({strobe.wrStatus, strobe.wrEnable, strobe.wrTrig, strobe.wrLevel,
                   strobe.wrHold, strobe.wrFall, strobe.wrRise}) == 1));
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [2*DATA_W-1:0]             pinIn,
  input  ctrlStrobeT                      strobe,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               rdData,
  output logic                            irqOut,
  output logic                            pendValid,
  output logic [$clog2(2*DATA_W)-1:0]     pendPin
);
  localparam int NPINS      = 2 * DATA_W;
  localparam int HALF_IDX_W = $clog2(DATA_W);

  logic [NPINS-1:0] syncA, syncB, syncPrev;
  logic [NPINS-1:0] enReg, trigReg, levelReg, holdReg, fallReg, riseReg;
  logic [NPINS-1:0] statusReg, statusNext;
  logic [NPINS-1:0] act, riseSeen, fallSeen, evt, w1cMask, pending;
  logic [NPINS-1:0] holdEdge, liveEdge;

  // Two-flop synchroniser plus one stage of history for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign act      = ~(syncB ^ levelReg);
  assign riseSeen = syncB & ~syncPrev;
  assign fallSeen = ~syncB & syncPrev;
  assign evt      = (riseSeen & riseReg) | (fallSeen & fallReg);

  // Configuration registers, one 16-bit half per strobe bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      trigReg  <= '0;
      levelReg <= '0;
      holdReg  <= '0;
      fallReg  <= '0;
      riseReg  <= '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (strobe.wrEnable[h]) enReg[h*DATA_W +: DATA_W]    <= wrData;
        if (strobe.wrTrig[h])   trigReg[h*DATA_W +: DATA_W]  <= wrData;
        if (strobe.wrLevel[h])  levelReg[h*DATA_W +: DATA_W] <= wrData;
        if (strobe.wrHold[h])   holdReg[h*DATA_W +: DATA_W]  <= wrData;
        if (strobe.wrFall[h])   fallReg[h*DATA_W +: DATA_W]  <= wrData;
        if (strobe.wrRise[h])   riseReg[h*DATA_W +: DATA_W]  <= wrData;
      end
    end
  end

  genvar gh;
  generate
    for (gh = 0; gh < 2; gh++) begin : g_w1c
      assign w1cMask[gh*DATA_W +: DATA_W] = strobe.wrStatus[gh] ? wrData : '0;
    end
  endgenerate

  assign holdEdge = trigReg & holdReg;
  assign liveEdge = trigReg & ~holdReg;

  // A new event overrides a clear in the same cycle
  assign statusNext = (holdEdge & (evt | (statusReg & ~w1cMask)))
                    | (liveEdge & evt)
                    | (~trigReg & act);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= statusNext;
  end

  assign pending = statusReg & enReg;

  // Per-half lowest-set search; the lower half always wins
  logic [1:0][HALF_IDX_W-1:0] halfIdx;
  logic [1:0]                 halfAny;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      halfIdx[h] = '0;
      halfAny[h] = |pending[h*DATA_W +: DATA_W];
      for (int i = DATA_W - 1; i >= 0; i--) begin
        if (pending[h*DATA_W + i]) halfIdx[h] = HALF_IDX_W'(i);
      end
    end
  end

  assign pendValid = |halfAny;
  assign pendPin   = halfAny[0] ? {1'b0, halfIdx[0]} :
                     halfAny[1] ? {1'b1, halfIdx[1]} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |pending;
  end

  // Read mux
  logic [NPINS-1:0] rdFull;
  always_comb begin
    case (strobe.rdKind)
      KIND_STATUS: rdFull = statusReg;
      KIND_ENABLE: rdFull = enReg;
      KIND_TRIG:   rdFull = trigReg;
      KIND_LEVEL:  rdFull = levelReg;
      KIND_HOLD:   rdFull = holdReg;
      KIND_FALL:   rdFull = fallReg;
      KIND_RISE:   rdFull = riseReg;
      default:     rdFull = '0;
    endcase
  end
  assign rdData = strobe.rdHalf ? rdFull[NPINS-1:DATA_W] : rdFull[DATA_W-1:0];

  // R3: an unopposed clear of a held edge bit takes effect
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(w1cMask & holdEdge & ~evt)) == '0));

  // R4: level-mode bits track the qualified input
  assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & ~$past(trigReg)) == $past(act & ~trigReg)));

  // R6: live edge bits never persist without a fresh event
  assert_live_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(liveEdge & ~evt)) == '0));

  // R7: the reported pin is really pending
  assert_pin_is_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> pending[pendPin]);

  // R8: nothing pending gives no valid pin
  assert_spurious_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> (!pendValid && pendPin == '0));

  // R9: combined line lags the pending set by one clock
  assert_irq_registered_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(pendValid)));

  // R11: a held event survives a clear in the same cycle
  assert_event_beats_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(evt & holdEdge)) == $past(evt & holdEdge)));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2*DATA_W-1:0]         pinIn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic [DATA_W-1:0]           busWrData,
  output logic [DATA_W-1:0]           busRdData,
  output logic                        irqOut,
  output logic                        pendValid,
  output logic [$clog2(2*DATA_W)-1:0] pendPin
);
  ctrlStrobeT strobe;

  gpio_irq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_irq_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .irqOut    (irqOut),
    .pendValid (pendValid),
    .pendPin   (pendPin)
  );
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;
  import gpio_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqOut, pendValid;
  logic [4:0]  pendPin;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .pendValid(pendValid), .pendPin(pendPin)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic checkVal(input string req, input logic [31:0] actual, input logic [31:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // All tasks are entered just after a falling edge
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [7:0] regAddr(input logic [7:0] base, input int pin);
    return (pin >= 16) ? base + 8'd2 : base;
  endfunction

  task automatic writeBoth(input logic [7:0] base, input logic [31:0] v);
    busWrite(base, v[15:0]);
    busWrite(base + 8'd2, v[31:16]);
  endtask

  task automatic checkPoint(input string req, input int p, input logic expBit);
    logic [15:0] rd;
    busRead(regAddr(OFF_STATUS, p), rd);
    checkVal({req, " status"}, 32'(rd[p % 16]), 32'(expBit));
    checkVal({req, " pendValid"}, 32'(pendValid), 32'(expBit));
    checkVal({req, " pendPin"}, 32'(pendPin), expBit ? 32'(p) : 32'd0);
  endtask

  initial begin
    logic [15:0] rd;
    logic [7:0] cfgBases [6];
    cfgBases = '{OFF_ENABLE, OFF_TRIG, OFF_LEVEL, OFF_HOLD, OFF_FALL, OFF_RISE};

    @(negedge clk);
    tick(2);
    // R1: reset state
    checkVal("R1 pendValid", 32'(pendValid), 0);
    checkVal("R1 pendPin", 32'(pendPin), 0);
    checkVal("R1 irqOut", 32'(irqOut), 0);
    for (int k = 0; k < 6; k++) begin
      for (int h = 0; h < 2; h++) begin
        busRead(cfgBases[k] + 8'(2*h), rd);
        checkVal("R1 config reg", 32'(rd), 0);
      end
    end
    rstN = 1'b1;
    tick(4);
    // R4: active-low level pins with input low report status
    busRead(OFF_STATUS, rd);
    checkVal("R4 status after reset", 32'(rd), 32'hFFFF);
    checkVal("R8 disabled pins not pending", 32'(pendValid), 0);

    // R2: readback of each configuration half
    for (int k = 0; k < 6; k++) begin
      for (int h = 0; h < 2; h++) begin
        busWrite(cfgBases[k] + 8'(2*h), 16'h1357 + 16'(k*16'h0411) + 16'(h*16'h2020));
      end
    end
    for (int k = 0; k < 6; k++) begin
      for (int h = 0; h < 2; h++) begin
        busRead(cfgBases[k] + 8'(2*h), rd);
        checkVal("R2 readback", 32'(rd), 32'(16'h1357 + 16'(k*16'h0411) + 16'(h*16'h2020)));
      end
    end
    busRead(8'h1C, rd);
    checkVal("R2 unmapped reads 0", 32'(rd), 0);
    for (int k = 0; k < 6; k++) writeBoth(cfgBases[k], 32'h0);

    // Sweep: every pin against every mode combination
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 32; c++) begin
        logic typ, lvl, hld, fal, ris;
        logic [31:0] m;
        logic base, expv;
        string req;
        typ = c[0]; lvl = c[1]; hld = c[2]; fal = c[3]; ris = c[4];
        m = 32'd1 << p;
        req = typ ? (hld ? "R6" : "R5") : "R4";
        writeBoth(OFF_ENABLE, m);
        writeBoth(OFF_TRIG, typ ? m : 32'h0);
        writeBoth(OFF_LEVEL, lvl ? m : 32'h0);
        writeBoth(OFF_HOLD, hld ? m : 32'h0);
        writeBoth(OFF_FALL, fal ? m : 32'h0);
        writeBoth(OFF_RISE, ris ? m : 32'h0);
        pinIn = '0;
        tick(4);
        writeBoth(OFF_STATUS, 32'hFFFF_FFFF);
        base = typ ? 1'b0 : ~lvl;
        checkPoint({req, " baseline"}, p, base);

        pinIn = m;
        tick(2);
        checkPoint("R10 not before third edge", p, base);
        tick(1);
        expv = typ ? ris : lvl;
        checkPoint({req, " after rise"}, p, expv);
        tick(1);
        expv = typ ? (hld & ris) : lvl;
        checkPoint({req, " rise +1"}, p, expv);

        pinIn = '0;
        tick(3);
        expv = typ ? (hld ? (ris | fal) : fal) : ~lvl;
        checkPoint({req, " after fall"}, p, expv);
        tick(1);
        expv = typ ? (hld & (ris | fal)) : ~lvl;
        checkPoint({req, " fall +1"}, p, expv);

        busWrite(regAddr(OFF_STATUS, p), 16'hFFFF);
        expv = typ ? 1'b0 : ~lvl;
        checkPoint(typ ? "R3 cleared" : "R4 clear no lasting effect", p, expv);
        tick(2);
        checkVal("R9 irqOut", 32'(irqOut), 32'(expv));
      end
    end

    // R3 and R11 on pin 5: edge rising, hold
    writeBoth(OFF_ENABLE, 32'h20);
    writeBoth(OFF_TRIG, 32'h20);
    writeBoth(OFF_LEVEL, 32'h0);
    writeBoth(OFF_HOLD, 32'h20);
    writeBoth(OFF_FALL, 32'h0);
    writeBoth(OFF_RISE, 32'h20);
    pinIn = '0;
    tick(4);
    writeBoth(OFF_STATUS, 32'hFFFF_FFFF);
    pinIn = 32'h20;
    tick(3);
    pinIn = '0;
    tick(3);
    checkPoint("R6 latched after input drops", 5, 1'b1);
    busWrite(OFF_STATUS, 16'h0000);
    checkPoint("R3 write zero keeps", 5, 1'b1);
    busWrite(OFF_STATUS, 16'hFFDF);
    checkPoint("R3 other bits do not clear", 5, 1'b1);
    pinIn = 32'h20;
    tick(2);
    busWrite(OFF_STATUS, 16'h0020);
    checkPoint("R11 event beats clear", 5, 1'b1);
    busWrite(OFF_STATUS, 16'h0020);
    checkPoint("R3 clear takes effect", 5, 1'b0);

    // R7/R8: priority with level, active-high, all enabled
    writeBoth(OFF_TRIG, 32'h0);
    writeBoth(OFF_HOLD, 32'h0);
    writeBoth(OFF_RISE, 32'h0);
    writeBoth(OFF_LEVEL, 32'hFFFF_FFFF);
    writeBoth(OFF_ENABLE, 32'hFFFF_FFFF);
    begin
      logic [31:0] pats [8];
      logic [31:0] ens  [8];
      pats = '{32'h0, 32'h8000_0001, 32'hFFFF_0000, 32'h0001_0000,
               32'h8000_0000, 32'h0000_8000, 32'h0010_0100, 32'h0400_0004};
      ens  = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000};
      for (int t = 0; t < 9; t++) begin
        logic [31:0] pat, en, pend;
        int expPin;
        pat = (t < 8) ? pats[t] : 32'h0F0F_F0F0;
        en  = (t < 8) ? ens[t] : 32'h0;
        writeBoth(OFF_ENABLE, en);
        pinIn = pat;
        tick(3);
        pend = pat & en;
        expPin = 0;
        for (int i = 31; i >= 0; i--) if (pend[i]) expPin = i;
        checkVal(pend != 0 ? "R7 pendValid" : "R8 pendValid", 32'(pendValid), 32'(pend != 0));
        checkVal(pend != 0 ? "R7 pendPin" : "R8 pendPin", 32'(pendPin), 32'(expPin));
        tick(1);
        checkVal("R9 irqOut", 32'(irqOut), 32'(pend != 0));
      end
    end

    finishRun();
  end
endmodule